// File: doc/BRIEF.md
# Single-Channel Short-Address DMA Engine with Auto-Reload

This block is one DMA channel for data movement between a stepping memory location and a fixed peripheral location. Software programs a memory pointer, a peripheral address, an 8-bit transfer count and a mode word through a small register port. It then sets the run bit. Each pulse on the selected request line moves one byte or one 16-bit word. The move is a read beat from the source followed by a write beat to the destination, issued on a single-beat bus master port.

When run is set, the channel copies the memory pointer and the count into shadow storage. In repeat operation, it uses these copies to rewind itself when the count is exhausted, and it keeps serving requests. With interrupt enable also set, the channel works instead in idle fashion. The memory pointer stays parked, the count still runs down, and the channel stops and raises its end interrupt. With repeat off, the pointer steps and the channel stops at the end of the count.

Top module: `dma_sc_chan`

## Requirements
- R1: After reset the run bit, interrupt, bus request, acknowledge outputs and every readable register are zero.
- R2: Each accepted request produces one read beat from the source and then one write beat to the destination carrying the read data. Mode bit 2 set means peripheral-to-memory, clear means memory-to-peripheral. Byte moves carry data in bits 7:0 with bits 15:8 zero. Word moves use the little-endian byte pair at the address.
- R3: Outside idle operation, the memory pointer (register 0) moves after every transfer by 1 for bytes or 2 for words (mode bit 0 = word). It moves down when mode bit 1 is set and up otherwise, modulo the address width. The peripheral address (register 1) is never altered.
- R4: The count (register 2) drops by one per transfer. The transfer that finds it at 1 is the last one. A programmed 0 gives 256 transfers.
- R5: Repeat operation (mode bit 3 set, control bit 1 clear): the last transfer restores the pointer and count captured when run was set. Run stays 1, no interrupt is raised, and requests keep being served.
- R6: Idle operation (mode bit 3 set, control bit 1 set): the pointer never moves. The last transfer clears run and sets the interrupt, and later requests move nothing.
- R7: With mode bit 3 clear, the last transfer clears run. It raises the interrupt only if control bit 1 is set. Later requests move nothing.
- R8: Only the request line selected by mode bits 7:4 starts transfers. Other lines, and select values at or above the number of lines, have no effect.
- R9: A request that arrives while a transfer is under way is served right after it. Several such requests merge into one extra transfer.
- R10: While run is 1, writes to registers 0 to 3 are ignored.
- R11: While mode bit 8 (full-address) is 1, writing 1 to control bit 0 leaves run at 0.
- R12: With mode bit 9 set, the acknowledge bit of the selected line pulses once per completed transfer. With mode bit 9 clear, no acknowledge bit ever pulses.
- R13: Any write to the control register (register 4: bit 0 run, bit 1 interrupt enable, bit 2 interrupt status, read-only) clears the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| req_in | input | NSRC | Transfer request lines |
| req_ack | output | NSRC | Request-clear pulse to the activating source |
| bus_req | output | 1 | Bus beat active |
| bus_we | output | 1 | Beat is a write |
| bus_wide | output | 1 | Beat is 16 bits (else 8) |
| bus_addr | output | AW | Beat byte address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_rdy | input | 1 | Beat completes |
| end_irq | output | 1 | Transfer-end interrupt |

## Verification
The bench builds the channel with a 10-bit address and four request lines. A 1 KiB memory model can then hold the whole address space, with a contents pattern computed from the address. Select values 4 to 15 become reachable as out-of-range triggers. The bench sweeps every combination of size, direction, step sign and the four operating modes at counts 1 to 3. In repeat mode it runs past two reloads. A separate run covers the count value 0, which gives 256 transfers.

// File: rtl/dma_sc_pkg.sv
package dma_sc_pkg;
  localparam int TRIG_W = 4;
  localparam int CNT_W  = 8;
  localparam int DW     = 16;
  localparam int RA_W   = 3;

  localparam logic [RA_W-1:0] RA_MEM  = 3'd0;
  localparam logic [RA_W-1:0] RA_PER  = 3'd1;
  localparam logic [RA_W-1:0] RA_CNT  = 3'd2;
  localparam logic [RA_W-1:0] RA_MODE = 3'd3;
  localparam logic [RA_W-1:0] RA_CTRL = 3'd4;

  typedef struct packed {
    logic              ack_src;
    logic              full_addr;
    logic [TRIG_W-1:0] trig;
    logic              rep;
    logic              to_mem;
    logic              dec;
    logic              wide;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  typedef enum logic [1:0] {BS_IDLE, BS_RD, BS_WR} bus_st_e;

  function automatic logic [15:0] step_addr(logic [15:0] a, logic wide, logic dec);
    logic [15:0] d;
    d = wide ? 16'd2 : 16'd1;
    return dec ? a - d : a + d;
  endfunction

  function automatic logic count_last(logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction
endpackage

// File: rtl/dma_sc_regs.sv
module dma_sc_regs
  import dma_sc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [RA_W-1:0]  cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  input  logic             xfer_done,
  output logic [AW-1:0]    mem_addr,
  output logic [AW-1:0]    per_addr,
  output logic [CNT_W-1:0] count,
  output mode_t            mode,
  output logic             run,
  output logic             irq,
  output logic             rpt_mode,
  output logic             idle_mode
);
  logic [AW-1:0]    mem_q, per_q, mem_sh_q, mem_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_sh_q, cnt_nxt;
  mode_t            mode_q;
  logic             run_q, ie_q, irq_q;
  logic             last_w, reload_w, stop_w;
  logic [15:0]      mem_ext_w, mem_step_w;

  assign rpt_mode  = mode_q.rep & ~ie_q;
  assign idle_mode = mode_q.rep & ie_q;
  assign last_w    = count_last(cnt_q);
  assign reload_w  = rpt_mode & last_w;
  assign stop_w    = last_w & ~rpt_mode;

  assign mem_ext_w  = 16'(mem_q);
  assign mem_step_w = step_addr(mem_ext_w, mode_q.wide, mode_q.dec);

  always_comb begin
    if (reload_w)       mem_nxt = mem_sh_q;
    else if (idle_mode) mem_nxt = mem_q;
    else                mem_nxt = mem_step_w[AW-1:0];
    cnt_nxt = reload_w ? cnt_sh_q : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q    <= '0;
      per_q    <= '0;
      mem_sh_q <= '0;
      cnt_q    <= '0;
      cnt_sh_q <= '0;
      mode_q   <= '0;
      run_q    <= 1'b0;
      ie_q     <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (cfg_wr && !run_q) begin
        case (cfg_addr)
          RA_MEM:  mem_q  <= cfg_wdata[AW-1:0];
          RA_PER:  per_q  <= cfg_wdata[AW-1:0];
          RA_CNT:  cnt_q  <= cfg_wdata[CNT_W-1:0];
          RA_MODE: mode_q <= mode_t'(cfg_wdata[MODE_W-1:0]);
          default: ;
        endcase
      end
      if (cfg_wr && cfg_addr == RA_CTRL) begin
        ie_q  <= cfg_wdata[1];
        irq_q <= 1'b0;
        if (!cfg_wdata[0]) begin
          run_q <= 1'b0;
        end else if (!mode_q.full_addr && !run_q) begin
          run_q    <= 1'b1;
          mem_sh_q <= mem_q;
          cnt_sh_q <= cnt_q;
        end
      end
      if (xfer_done) begin
        mem_q <= mem_nxt;
        cnt_q <= cnt_nxt;
        if (stop_w) run_q <= 1'b0;
        if (stop_w && ie_q) irq_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      RA_MEM:  cfg_rdata = 16'(mem_q);
      RA_PER:  cfg_rdata = 16'(per_q);
      RA_CNT:  cfg_rdata = 16'(cnt_q);
      RA_MODE: cfg_rdata = 16'(mode_q);
      RA_CTRL: cfg_rdata = {13'd0, irq_q, ie_q, run_q};
      default: cfg_rdata = '0;
    endcase
  end

  assign mem_addr = mem_q;
  assign per_addr = per_q;
  assign count    = cnt_q;
  assign mode     = mode_q;
  assign run      = run_q;
  assign irq      = irq_q;
endmodule

// File: rtl/dma_sc_trig.sv
module dma_sc_trig
  import dma_sc_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_in,
  input  logic [TRIG_W-1:0] trig,
  input  logic              run,
  input  logic              take,
  input  logic              done,
  input  logic              ack_en,
  output logic              pend,
  output logic [NSRC-1:0]   req_ack
);
  localparam int NSEL = 1 << TRIG_W;

  logic [NSEL-1:0] hit_v;
  logic            sel_w;
  logic            pend_q;

  for (genvar i = 0; i < NSEL; i++) begin : g_hit
    if (i < NSRC) begin : g_live
      assign hit_v[i] = req_in[i];
    end else begin : g_none
      assign hit_v[i] = 1'b0;
    end
  end

  for (genvar j = 0; j < NSRC; j++) begin : g_ack
    assign req_ack[j] = done & ack_en & (trig == TRIG_W'(j));
  end

  assign sel_w = hit_v[trig];

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= run & ((pend_q & ~take) | sel_w);
  end

  assign pend = pend_q;
endmodule

// File: rtl/dma_sc_bus.sv
module dma_sc_bus
  import dma_sc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          pend,
  input  logic [AW-1:0] mem_addr,
  input  logic [AW-1:0] per_addr,
  input  logic          wide,
  input  logic          to_mem,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rdy,
  output logic          take,
  output logic          xfer_done,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_wide,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata
);
  bus_st_e       st_q;
  logic [DW-1:0] data_q;
  logic [AW-1:0] src_w, dst_w;

  assign take      = (st_q == BS_IDLE) & run & pend;
  assign xfer_done = (st_q == BS_WR) & bus_rdy;
  assign src_w     = to_mem ? per_addr : mem_addr;
  assign dst_w     = to_mem ? mem_addr : per_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= BS_IDLE;
      data_q <= '0;
    end else begin
      case (st_q)
        BS_IDLE: if (take) st_q <= BS_RD;
        BS_RD: if (bus_rdy) begin
          data_q <= wide ? bus_rdata : {8'h00, bus_rdata[7:0]};
          st_q   <= BS_WR;
        end
        BS_WR: if (bus_rdy) st_q <= BS_IDLE;
        default: st_q <= BS_IDLE;
      endcase
    end
  end

  assign bus_req   = (st_q != BS_IDLE);
  assign bus_we    = (st_q == BS_WR);
  assign bus_wide  = wide;
  assign bus_addr  = (st_q == BS_WR) ? dst_w : src_w;
  assign bus_wdata = data_q;
endmodule

// File: rtl/dma_sc_chan.sv
module dma_sc_chan
  import dma_sc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_addr,
  input  logic [15:0]     cfg_wdata,
  output logic [15:0]     cfg_rdata,
  input  logic [NSRC-1:0] req_in,
  output logic [NSRC-1:0] req_ack,
  output logic            bus_req,
  output logic            bus_we,
  output logic            bus_wide,
  output logic [AW-1:0]   bus_addr,
  output logic [15:0]     bus_wdata,
  input  logic [15:0]     bus_rdata,
  input  logic            bus_rdy,
  output logic            end_irq
);
  logic [AW-1:0]    mem_addr_w, per_addr_w;
  logic [CNT_W-1:0] count_w;
  mode_t            mode_w;
  logic             run_w, rpt_mode_w, idle_mode_w, full_w;
  logic             pend_w, take_w, xfer_done_w;

  assign full_w = mode_w.full_addr;

  dma_sc_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xfer_done(xfer_done_w),
    .mem_addr(mem_addr_w), .per_addr(per_addr_w), .count(count_w),
    .mode(mode_w), .run(run_w), .irq(end_irq),
    .rpt_mode(rpt_mode_w), .idle_mode(idle_mode_w)
  );

  dma_sc_trig #(.NSRC(NSRC)) u_trig (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig(mode_w.trig),
    .run(run_w), .take(take_w), .done(xfer_done_w), .ack_en(mode_w.ack_src),
    .pend(pend_w), .req_ack(req_ack)
  );

  dma_sc_bus #(.AW(AW)) u_bus (
    .clk(clk), .rst_n(rst_n), .run(run_w), .pend(pend_w),
    .mem_addr(mem_addr_w), .per_addr(per_addr_w), .wide(mode_w.wide),
    .to_mem(mode_w.to_mem), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
    .take(take_w), .xfer_done(xfer_done_w), .bus_req(bus_req),
    .bus_we(bus_we), .bus_wide(bus_wide), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata)
  );
endmodule

// File: rtl/dma_sc_chan_chk.sv
module dma_sc_chan_chk #(
  parameter int AW   = 16,
  parameter int NSRC = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic            bus_req,
  input logic            bus_we,
  input logic            bus_rdy,
  input logic            end_irq,
  input logic            run_w,
  input logic            full_w,
  input logic            xfer_done_w,
  input logic            rpt_mode_w,
  input logic            idle_mode_w,
  input logic [AW-1:0]   mem_addr_w,
  input logic [7:0]      count_w,
  input logic [NSRC-1:0] req_ack
);
  a_r2_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !bus_we);

  a_r2_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_we)));

  a_r4_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_done_w && !cfg_wr) |=> $stable(count_w));

  a_r5_repeat_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done_w && rpt_mode_w) |=> run_w);

  a_r6_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done_w && idle_mode_w && run_w) |=> $stable(mem_addr_w));

  a_r7_irq_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |-> !run_w);

  a_r11_full_blocks_run: assert property (@(posedge clk) disable iff (!rst_n)
    full_w |-> !run_w);

  a_r12_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ack));

  a_r12_ack_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack != '0) |-> xfer_done_w);
endmodule

bind dma_sc_chan dma_sc_chan_chk #(.AW(AW), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .bus_req(bus_req),
  .bus_we(bus_we), .bus_rdy(bus_rdy), .end_irq(end_irq), .run_w(run_w),
  .full_w(full_w), .xfer_done_w(xfer_done_w), .rpt_mode_w(rpt_mode_w),
  .idle_mode_w(idle_mode_w), .mem_addr_w(mem_addr_w), .count_w(count_w),
  .req_ack(req_ack)
);

// File: tb/tb_dma_sc_chan.sv
module tb_dma_sc_chan;
  localparam int AW   = 10;
  localparam int NSRC = 4;
  localparam int MSZ  = 1 << AW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_wr = 1'b0;
  logic [2:0]      cfg_addr = '0;
  logic [15:0]     cfg_wdata = '0;
  logic [15:0]     cfg_rdata;
  logic [NSRC-1:0] req_in = '0;
  logic [NSRC-1:0] req_ack;
  logic            bus_req, bus_we, bus_wide;
  logic [AW-1:0]   bus_addr;
  logic [15:0]     bus_wdata;
  logic [15:0]     bus_rdata = '0;
  logic            bus_rdy = 1'b0;
  logic            end_irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dma_sc_chan #(.AW(AW), .NSRC(NSRC)) dut (.*);

  function automatic logic [7:0] pat(int a);
    return 8'((a % MSZ) * 7 + 13) ^ 8'h5A;
  endfunction

  logic [7:0]    mem [0:MSZ-1];
  logic          mem_init = 1'b0;
  logic [AW-1:0] rd_hold = '0, log_rd = '0, log_wr = '0;
  logic [15:0]   log_data = '0;
  int            nwr = 0;
  int            ack_cnt = 0;
  int            ack_bad = 0;

  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < MSZ; i++) mem[i] <= pat(i);
    end
    if (!rst_n) begin
      bus_rdy <= 1'b0;
    end else if (bus_req && !bus_rdy) begin
      bus_rdy <= 1'b1;
      if (!bus_we) begin
        rd_hold   <= bus_addr;
        bus_rdata <= bus_wide ? {mem[AW'(bus_addr + 1)], mem[bus_addr]}
                              : {8'h00, mem[bus_addr]};
      end
    end else if (bus_rdy) begin
      bus_rdy <= 1'b0;
      if (bus_req && bus_we) begin
        mem[bus_addr] <= bus_wdata[7:0];
        if (bus_wide) mem[AW'(bus_addr + 1)] <= bus_wdata[15:8];
        log_rd   <= rd_hold;
        log_wr   <= bus_addr;
        log_data <= bus_wdata;
        nwr      <= nwr + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && req_ack != '0) begin
      ack_cnt <= ack_cnt + 1;
      if (req_ack != 4'b1000) ack_bad <= ack_bad + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic pulse(input logic [NSRC-1:0] v);
    @(negedge clk);
    req_in = v;
    @(negedge clk);
    req_in = '0;
  endtask

  task automatic wait_xfer(input int start, output bit got);
    got = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (nwr != start) got = 1'b1;
    end
  endtask

  task automatic reinit;
    @(negedge clk); mem_init = 1'b1;
    @(negedge clk); mem_init = 1'b0;
  endtask

  function automatic logic [15:0] mk_mode(int ack, int full, int trig, int rep, int dir, int dec, int wide);
    return 16'((ack << 9) | (full << 8) | (trig << 4) | (rep << 3) | (dir << 2) | (dec << 1) | wide);
  endfunction

  // md: 0 plain with irq, 1 plain without irq, 2 repeat, 3 idle
  task automatic run_scn(input int wide, input int dec, input int dir, input int md, input int cnt);
    logic [AW-1:0] em, st_mem, per;
    logic [7:0]    ec;
    logic [15:0]   rv, exp_d;
    bit            erun, eirq, got, last;
    int            ntr, start;
    logic [AW-1:0] src, dst;
    string         mt;
    st_mem = 10'h100; per = 10'h300;
    mt = (md == 2) ? "R5" : (md == 3) ? "R6" : "R7";
    wreg(3'd4, 16'h0000);
    reinit();
    wreg(3'd0, 16'(st_mem));
    wreg(3'd1, 16'(per));
    wreg(3'd2, 16'(cnt));
    wreg(3'd3, mk_mode(0, 0, 1, (md >= 2) ? 1 : 0, dir, dec, wide));
    wreg(3'd4, ((md == 0 || md == 3) ? 16'h0002 : 16'h0000) | 16'h0001);
    em = st_mem; ec = 8'(cnt); erun = 1'b1; eirq = 1'b0;
    ntr = (md == 2) ? 2 * cnt + 1 : cnt + 1;
    for (int k = 0; k < ntr; k++) begin
      start = nwr;
      pulse(4'b0010);
      wait_xfer(start, got);
      if (erun) begin
        check(got, "R2 transfer missing", int'(got), 1);
        src = dir ? per : em;
        dst = dir ? em : per;
        exp_d = wide ? {pat(int'(src) + 1), pat(int'(src))} : {8'h00, pat(int'(src))};
        check(log_rd == src, "R2 read address", int'(log_rd), int'(src));
        check(log_wr == dst, "R2 write address", int'(log_wr), int'(dst));
        check(log_data == exp_d, "R2 write data", int'(log_data), int'(exp_d));
        last = (ec == 8'd1);
        if (md == 2 && last) begin
          em = st_mem; ec = 8'(cnt);
        end else begin
          if (md != 3) em = dec ? em - AW'(wide ? 2 : 1) : em + AW'(wide ? 2 : 1);
          ec = ec - 8'd1;
          if (last) begin erun = 1'b0; eirq = (md == 0 || md == 3); end
        end
      end else begin
        check(!got, {mt, " transfer after stop"}, int'(got), 0);
      end
      rreg(3'd0, rv);
      check(rv == 16'(em), (md == 3) ? "R6 pointer" : "R3 pointer", int'(rv), int'(em));
      rreg(3'd1, rv);
      check(rv == 16'(per), "R3 peripheral address", int'(rv), int'(per));
      rreg(3'd2, rv);
      check(rv == 16'(ec), "R4 count", int'(rv), int'(ec));
      rreg(3'd4, rv);
      check(rv[0] == erun, {mt, " run"}, int'(rv[0]), int'(erun));
      check(end_irq == eirq, {mt, " interrupt"}, int'(end_irq), int'(eirq));
    end
  endtask

  initial begin
    logic [15:0] rv;
    bit          got;
    int          start;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rreg(3'(a), rv);
      check(rv == 16'h0, "R1 register reset", int'(rv), 0);
    end
    check(!bus_req && !end_irq && req_ack == '0, "R1 outputs reset",
          int'({bus_req, end_irq, req_ack}), 0);

    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 2; d++)
        for (int r = 0; r < 2; r++)
          for (int m = 0; m < 4; m++)
            for (int c = 1; c <= 3; c++)
              run_scn(w, d, r, m, c);

    // R12 no acks while ack bit was clear
    check(ack_cnt == 0, "R12 ack without enable", ack_cnt, 0);

    // R8 trigger selection
    wreg(3'd4, 16'h0000);
    wreg(3'd0, 16'h0100);
    wreg(3'd1, 16'h0300);
    wreg(3'd2, 16'h0003);
    wreg(3'd3, mk_mode(0, 0, 2, 0, 0, 0, 0));
    wreg(3'd4, 16'h0003);
    start = nwr;
    pulse(4'b1011);
    wait_xfer(start, got);
    check(!got, "R8 other lines ignored", int'(got), 0);
    pulse(4'b0100);
    wait_xfer(start, got);
    check(got, "R8 selected line", int'(got), 1);
    wreg(3'd4, 16'h0000);
    wreg(3'd3, mk_mode(0, 0, 5, 0, 0, 0, 0));
    wreg(3'd4, 16'h0001);
    start = nwr;
    pulse(4'b1111);
    wait_xfer(start, got);
    check(!got, "R8 out-of-range select", int'(got), 0);

    // R9 held and merged requests
    wreg(3'd4, 16'h0000);
    wreg(3'd0, 16'h0100);
    wreg(3'd2, 16'h0005);
    wreg(3'd3, mk_mode(0, 0, 0, 0, 0, 0, 0));
    wreg(3'd4, 16'h0001);
    start = nwr;
    pulse(4'b0001);
    @(negedge clk);
    pulse(4'b0001);
    pulse(4'b0001);
    repeat (60) @(negedge clk);
    check(nwr - start == 2, "R9 held requests merge", nwr - start, 2);

    // R10 writes ignored while running
    wreg(3'd0, 16'h0055);
    wreg(3'd2, 16'h0009);
    wreg(3'd3, 16'h0000);
    rreg(3'd0, rv);
    check(rv == 16'h0102, "R10 pointer frozen", int'(rv), 'h102);
    rreg(3'd2, rv);
    check(rv == 16'h0003, "R10 count frozen", int'(rv), 3);
    rreg(3'd3, rv);
    check(rv == mk_mode(0, 0, 0, 0, 0, 0, 0), "R10 mode frozen", int'(rv), 0);

    // R11 full-address bit blocks run
    wreg(3'd4, 16'h0000);
    wreg(3'd3, mk_mode(0, 1, 0, 0, 0, 0, 0));
    wreg(3'd4, 16'h0001);
    rreg(3'd4, rv);
    check(rv[0] == 1'b0, "R11 run blocked", int'(rv[0]), 0);
    start = nwr;
    pulse(4'b0001);
    wait_xfer(start, got);
    check(!got, "R11 no transfer", int'(got), 0);

    // R12 acknowledge pulses, then R13 interrupt clear
    wreg(3'd3, mk_mode(1, 0, 3, 0, 0, 0, 0));
    wreg(3'd2, 16'h0002);
    wreg(3'd4, 16'h0003);
    for (int k = 0; k < 2; k++) begin
      start = nwr;
      pulse(4'b1000);
      wait_xfer(start, got);
    end
    check(ack_cnt == 2, "R12 ack count", ack_cnt, 2);
    check(ack_bad == 0, "R12 ack line", ack_bad, 0);
    check(end_irq == 1'b1, "R13 interrupt set", int'(end_irq), 1);
    wreg(3'd4, 16'h0002);
    check(end_irq == 1'b0, "R13 interrupt cleared", int'(end_irq), 0);

    // R4 count 0 means 256
    wreg(3'd4, 16'h0000);
    wreg(3'd0, 16'h0000);
    wreg(3'd2, 16'h0000);
    wreg(3'd3, mk_mode(0, 0, 0, 0, 0, 0, 0));
    wreg(3'd4, 16'h0003);
    start = nwr;
    for (int k = 0; k < 255; k++) begin
      pulse(4'b0001);
      repeat (8) @(negedge clk);
    end
    rreg(3'd2, rv);
    check(rv == 16'h0001 && nwr - start == 255, "R4 count after 255", int'(rv), 1);
    check(end_irq == 1'b0, "R4 no end before 256", int'(end_irq), 0);
    pulse(4'b0001);
    repeat (10) @(negedge clk);
    rreg(3'd4, rv);
    check(end_irq == 1'b1 && rv[0] == 1'b0, "R4 end at 256", int'(rv), 'h6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule